// File: doc/BRIEF.md
# Octal-Exponent Floating Comparator

This block compares two 48-bit words that hold floating-point numbers with a base-8 exponent. The second stack element (`second_word`) is compared against the top of stack (`top_word`). The result is a one-hot 3-bit relation code. From that code the block also forms a 0/1 result word for one of six relational predicates, chosen by `pred_sel`.

Each word holds, from bit 47 down:
- bit 47: a flag bit, which the comparison ignores.
- bit 46: the mantissa sign, 1 meaning negative.
- bit 45: the exponent sign.
- bits 44:39: the exponent magnitude.
- bits 38:0: a 39-bit mantissa, that is 13 octal digits.

The value of a word is mantissa × 8^exponent. An integer is a word whose exponent is zero. Before magnitudes are compared, both operands are normalized one octal digit per clock.

A comparison starts with a one-cycle `start` pulse while the block is idle. It ends with a one-cycle `done` pulse, and the results stay valid until the next comparison completes. The controller walks through five states:
- IDLE: waits for `start`, then loads the operands.
- CLASS: takes the zero/sign shortcut to DONE when it applies, and otherwise moves to NORM.
- NORM: shifts each operand that is not yet normalized, one digit per cycle. It moves to CMP once both operands are normalized or the shift limit is reached.
- CMP: latches the exponent/mantissa decision and moves to DONE.
- DONE: pulses `done` and returns to IDLE.

Top module: `octfp_compare`

## Requirements
- R1: `rel_code` at `done` is one-hot: 3'b001 means the two values are equal, 3'b100 means second > top, and 3'b010 means second < top.
- R2: When both mantissas (bits 38:0) are zero, the result is equal, whatever the exponents and sign bits are.
- R3: When only one mantissa is zero, the other operand's sign alone decides. With top zero, a negative second gives 3'b010 and a positive second gives 3'b100. With second zero, a negative top gives 3'b100 and a positive top gives 3'b010.
- R4: With both mantissas nonzero and the mantissa signs (bit 46) different, the negative operand is the lesser one, whatever the magnitudes are.
- R5: With equal signs, each operand is normalized by 3-bit left shifts, with its exponent decremented on each shift, until the top octal digit is nonzero. The normalized exponents are compared first and then the mantissas. Different encodings of the same value, such as mantissa 8 with exponent 0 against mantissa 1 with exponent 1, compare equal. At most 13 shifts are taken per operand.
- R6: When both operands are negative, the magnitude ordering is inverted.
- R7: `pred_word` is 0 or 1 in bit 0, and the select is latched at `start`. The selects are:
  - 0, greater or equal: code bit 0 or bit 2 is set.
  - 1, greater: the code is 4.
  - 2, not equal: the code is not 1.
  - 3, less or equal: code bit 0 or bit 1 is set.
  - 4, less: the code is 2.
  - 5, equal: the code is 1.
  - 6 and 7: always 0.
- R8: `start` is taken only in IDLE, and a `start` while `busy` is ignored. `done` is a single-cycle pulse that arrives at most 16 cycles after `start`. `busy` is low again in the cycle after `done`.
- R9: The flag bit (bit 47) of either operand has no effect on the result.
- R10: After reset, `busy`, `done`, `rel_code` and `pred_word` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a comparison (taken only when idle) |
| second_word | input | 48 | Second stack element |
| top_word | input | 48 | Top of stack |
| pred_sel | input | 3 | Predicate select, latched at start |
| busy | output | 1 | Comparison in progress |
| done | output | 1 | One-cycle completion pulse |
| rel_code | output | 3 | One-hot relation code |
| pred_word | output | 48 | Selected predicate as a 0/1 word |

## Verification
The bench runs several kinds of input pattern, and each one separates a different part of the decision logic:
- Pairs of equal value written with different exponents show whether normalization and the exponent-then-mantissa order are right.
- Pairs with opposite signs and wildly different magnitudes separate the sign shortcut from the magnitude path.
- Zero mantissas carrying junk exponents and signs expose a zero test that looks at more than the mantissa.
- Both-negative pairs catch a missing inversion.
- Mantissas of 1, which need the full shift depth, test the shift limit and the latency bound.
- Sweeping all eight selects over less, equal and greater results tells the six predicates apart.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CLASS = 3'd1,
        ST_NORM  = 3'd2,
        ST_CMP   = 3'd3,
        ST_DONE  = 3'd4
    } cmp_state_t;

    typedef enum logic [2:0] {
        PS_GEQ = 3'd0,
        PS_GTR = 3'd1,
        PS_NEQ = 3'd2,
        PS_LEQ = 3'd3,
        PS_LSS = 3'd4,
        PS_EQL = 3'd5
    } pred_sel_t;

    localparam logic [2:0] REL_EQ = 3'b001;
    localparam logic [2:0] REL_LT = 3'b010;
    localparam logic [2:0] REL_GT = 3'b100;

endpackage

// File: rtl/fcmp_norm.sv
module fcmp_norm #(
    parameter int EXP_W  = 6,
    parameter int MANT_W = 39,
    parameter int DIG_W  = 3,
    localparam int SE_W  = EXP_W + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [MANT_W-1:0]       ld_mant,
    input  logic signed [SE_W-1:0]  ld_exp,
    input  logic                    step,
    output logic [MANT_W-1:0]       mant,
    output logic signed [SE_W-1:0]  expo,
    output logic                    is_norm,
    output logic                    is_zero
);
    localparam logic signed [SE_W-1:0] ONE = SE_W'(1);

    logic [MANT_W-1:0]      mant_q;
    logic signed [SE_W-1:0] exp_q;

    assign is_norm = |mant_q[MANT_W-1 -: DIG_W];
    assign is_zero = (mant_q == '0);
    assign mant    = mant_q;
    assign expo    = exp_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mant_q <= '0;
            exp_q  <= '0;
        end else if (load) begin
            mant_q <= ld_mant;
            exp_q  <= ld_exp;
        end else if (step && !is_norm) begin
            mant_q <= {mant_q[MANT_W-DIG_W-1:0], {DIG_W{1'b0}}};
            exp_q  <= exp_q - ONE;
        end
    end

    // R5: each digit shift lowers the exponent by exactly one
    p_exp_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !is_norm) |=> (exp_q == $past(exp_q) - ONE));

    // R5: a normalized mantissa is left alone until the next load
    p_norm_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (is_norm && !load) |=> $stable(mant_q));

endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
    import fcmp_pkg::*;
#(
    parameter int EXP_W  = 6,
    parameter int MANT_W = 39,
    localparam int SE_W  = EXP_W + 2
) (
    input  logic                    sec_neg,
    input  logic                    top_neg,
    input  logic                    sec_zero,
    input  logic                    top_zero,
    input  logic signed [SE_W-1:0]  sec_exp,
    input  logic signed [SE_W-1:0]  top_exp,
    input  logic [MANT_W-1:0]       sec_mant,
    input  logic [MANT_W-1:0]       top_mant,
    output logic                    quick,
    output logic [2:0]              rel
);
    logic mag_gt;
    logic mag_eq;

    always_comb begin
        mag_gt = (sec_exp > top_exp) || ((sec_exp == top_exp) && (sec_mant > top_mant));
        mag_eq = (sec_exp == top_exp) && (sec_mant == top_mant);
        quick  = sec_zero || top_zero || (sec_neg != top_neg);

        if (sec_zero && top_zero) begin
            rel = REL_EQ;
        end else if (top_zero) begin
            rel = sec_neg ? REL_LT : REL_GT;
        end else if (sec_zero) begin
            rel = top_neg ? REL_GT : REL_LT;
        end else if (sec_neg != top_neg) begin
            rel = sec_neg ? REL_LT : REL_GT;
        end else if (mag_eq) begin
            rel = REL_EQ;
        end else if (mag_gt ^ sec_neg) begin
            rel = REL_GT;
        end else begin
            rel = REL_LT;
        end
    end

endmodule

// File: rtl/fcmp_pred.sv
module fcmp_pred
    import fcmp_pkg::*;
#(
    parameter int WORD_W = 48
) (
    input  logic [2:0]        rel,
    input  logic [2:0]        sel,
    output logic [WORD_W-1:0] word
);
    logic hit;

    always_comb begin
        case (sel)
            PS_GEQ:  hit = rel[0] | rel[2];
            PS_GTR:  hit = (rel == REL_GT);
            PS_NEQ:  hit = (rel != REL_EQ);
            PS_LEQ:  hit = rel[0] | rel[1];
            PS_LSS:  hit = (rel == REL_LT);
            PS_EQL:  hit = (rel == REL_EQ);
            default: hit = 1'b0;
        endcase
        word = {{(WORD_W-1){1'b0}}, hit};
    end

endmodule

// File: rtl/octfp_compare.sv
module octfp_compare
    import fcmp_pkg::*;
#(
    parameter int EXP_W  = 6,
    parameter int MANT_W = 39,
    parameter int DIG_W  = 3,
    localparam int WORD_W    = 3 + EXP_W + MANT_W,
    localparam int SE_W      = EXP_W + 2,
    localparam int MAX_SHIFT = MANT_W / DIG_W,
    localparam int CNT_W     = $clog2(MAX_SHIFT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] second_word,
    input  logic [WORD_W-1:0] top_word,
    input  logic [2:0]        pred_sel,
    output logic              busy,
    output logic              done,
    output logic [2:0]        rel_code,
    output logic [WORD_W-1:0] pred_word
);
    cmp_state_t state_q, state_d;

    logic             load, step;
    logic [CNT_W-1:0] cnt_q;
    logic [2:0]       rel_q, sel_q, rel_d;
    logic [1:0]       neg_q;
    logic             quick;

    logic [WORD_W-1:0]      op_word [2];
    logic [MANT_W-1:0]      ld_mant [2];
    logic signed [SE_W-1:0] ld_exp  [2];
    logic [MANT_W-1:0]      mant_n  [2];
    logic signed [SE_W-1:0] exp_n   [2];
    logic [1:0]             norm_n, zero_n;
    logic                   both_norm;
    logic                   unused_flags;

    assign op_word[0]   = second_word;
    assign op_word[1]   = top_word;
    assign unused_flags = ^{second_word[WORD_W-1], top_word[WORD_W-1]};

    // Index 0 is the second stack element, index 1 the top of stack
    for (genvar k = 0; k < 2; k++) begin : g_opnd
        logic signed [SE_W-1:0] mag_s;
        assign mag_s      = signed'({2'b00, op_word[k][MANT_W+EXP_W-1:MANT_W]});
        assign ld_exp[k]  = op_word[k][WORD_W-3] ? -mag_s : mag_s;
        assign ld_mant[k] = op_word[k][MANT_W-1:0];

        fcmp_norm #(.EXP_W(EXP_W), .MANT_W(MANT_W), .DIG_W(DIG_W)) i_norm (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (load),
            .ld_mant (ld_mant[k]),
            .ld_exp  (ld_exp[k]),
            .step    (step),
            .mant    (mant_n[k]),
            .expo    (exp_n[k]),
            .is_norm (norm_n[k]),
            .is_zero (zero_n[k])
        );
    end

    assign both_norm = &norm_n;

    fcmp_order #(.EXP_W(EXP_W), .MANT_W(MANT_W)) i_order (
        .sec_neg  (neg_q[0]),
        .top_neg  (neg_q[1]),
        .sec_zero (zero_n[0]),
        .top_zero (zero_n[1]),
        .sec_exp  (exp_n[0]),
        .top_exp  (exp_n[1]),
        .sec_mant (mant_n[0]),
        .top_mant (mant_n[1]),
        .quick    (quick),
        .rel      (rel_d)
    );

    fcmp_pred #(.WORD_W(WORD_W)) i_pred (
        .rel  (rel_q),
        .sel  (sel_q),
        .word (pred_word)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and datapath strobes
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        step    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    load    = 1'b1;
                    state_d = ST_CLASS;
                end
            end
            ST_CLASS: state_d = quick ? ST_DONE : ST_NORM;
            ST_NORM: begin
                if (both_norm || (cnt_q == CNT_W'(MAX_SHIFT))) state_d = ST_CMP;
                else                                            step    = 1'b1;
            end
            ST_CMP:  state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Output and operand side registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rel_q <= '0;
            sel_q <= '0;
            cnt_q <= '0;
            neg_q <= '0;
        end else begin
            if (load) begin
                sel_q <= pred_sel;
                cnt_q <= '0;
                neg_q <= {top_word[WORD_W-2], second_word[WORD_W-2]};
            end
            if (step) cnt_q <= cnt_q + CNT_W'(1);
            if ((state_q == ST_CLASS && quick) || state_q == ST_CMP) rel_q <= rel_d;
        end
    end

    assign busy     = (state_q != ST_IDLE);
    assign done     = (state_q == ST_DONE);
    assign rel_code = rel_q;

    // R1: the relation code is one-hot when the result is reported
    p_code_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($countones(rel_code) == 1));

    // R8: done is a single-cycle pulse
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: a start seen while busy does not disturb the latched select
    p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(sel_q));

    // R5: reaching the shift limit always ends normalization
    p_shift_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NORM && cnt_q == CNT_W'(MAX_SHIFT)) |=> (state_q == ST_CMP));

    // R3: the zero/sign shortcut finishes on the next cycle
    p_quick_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CLASS && quick) |=> done);

endmodule

// File: tb/test_octfp_compare.sv
module test_octfp_compare;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [47:0] second_word = '0;
    logic [47:0] top_word = '0;
    logic [2:0]  pred_sel = '0;
    logic        busy, done;
    logic [2:0]  rel_code;
    logic [47:0] pred_word;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    octfp_compare i_octfp_compare (
        .clk(clk), .rst_n(rst_n), .start(start),
        .second_word(second_word), .top_word(top_word), .pred_sel(pred_sel),
        .busy(busy), .done(done), .rel_code(rel_code), .pred_word(pred_word)
    );

    function automatic logic [47:0] mkw(bit flag, bit neg, int e, logic [38:0] m);
        int mag = (e < 0) ? -e : e;
        return {flag, neg, (e < 0), mag[5:0], m};
    endfunction

    function automatic real wval(logic [47:0] w);
        longint m = longint'({25'd0, w[38:0]});
        int e = int'(w[44:39]);
        real v;
        if (w[45]) e = -e;
        v = real'(m) * (2.0 ** (3.0 * real'(e)));
        return w[46] ? -v : v;
    endfunction

    function automatic logic [2:0] exp_rel(logic [47:0] s, logic [47:0] t);
        real a = wval(s);
        real b = wval(t);
        if (a == b) return 3'b001;
        return (a > b) ? 3'b100 : 3'b010;
    endfunction

    function automatic logic [47:0] exp_pred(logic [2:0] r, logic [2:0] sel);
        logic h;
        case (sel)
            3'd0: h = (r == 3'b001) || (r == 3'b100);
            3'd1: h = (r == 3'b100);
            3'd2: h = (r != 3'b001);
            3'd3: h = (r == 3'b001) || (r == 3'b010);
            3'd4: h = (r == 3'b010);
            3'd5: h = (r == 3'b001);
            default: h = 1'b0;
        endcase
        return {47'd0, h};
    endfunction

    task automatic check(bit ok, string req, logic [47:0] act, logic [47:0] expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic run_op(input logic [47:0] s, input logic [47:0] t, input logic [2:0] sel,
                          output int lat);
        @(negedge clk);
        second_word = s; top_word = t; pred_sel = sel; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic cmp_case(input logic [47:0] s, input logic [47:0] t, input logic [2:0] sel,
                            input string req);
        int lat;
        logic [2:0] er;
        run_op(s, t, sel, lat);
        er = exp_rel(s, t);
        check(done == 1'b1, {req, " done"}, 48'(done), 48'd1);
        check(rel_code == er, {req, " code"}, 48'(rel_code), 48'(er));
        check(pred_word == exp_pred(er, sel), {req, " pred"}, pred_word, exp_pred(er, sel));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        int lat;
        int unsigned junk;
        logic [47:0] s, t;
        junk = $urandom(32'd20240611);

        repeat (3) @(negedge clk);
        // R10: reset state
        check(busy == 1'b0, "R10 busy", 48'(busy), 48'd0);
        check(done == 1'b0, "R10 done", 48'(done), 48'd0);
        check(rel_code == 3'b000, "R10 code", 48'(rel_code), 48'd0);
        check(pred_word == 48'd0, "R10 pred", pred_word, 48'd0);
        rst_n = 1'b1;

        // R2: both mantissas zero, junk exponents and signs
        cmp_case(mkw(0, 1, 5, 0), mkw(0, 0, -7, 0), 3'd5, "R2");
        check(rel_code == 3'b001, "R2 explicit", 48'(rel_code), 48'd1);
        // R3: one zero mantissa
        cmp_case(mkw(0, 1, 3, 39'o7), mkw(0, 1, 9, 0), 3'd4, "R3");
        check(rel_code == 3'b010, "R3 top zero neg second", 48'(rel_code), 48'd2);
        cmp_case(mkw(0, 0, 3, 39'o7), mkw(0, 0, 9, 0), 3'd1, "R3");
        check(rel_code == 3'b100, "R3 top zero pos second", 48'(rel_code), 48'd4);
        cmp_case(mkw(0, 0, -2, 0), mkw(0, 1, 1, 39'o5), 3'd0, "R3");
        check(rel_code == 3'b100, "R3 second zero neg top", 48'(rel_code), 48'd4);
        // R4: differing signs, magnitudes opposing
        cmp_case(mkw(0, 1, 40, 39'o7777777777777), mkw(0, 0, -40, 39'o1), 3'd4, "R4");
        check(rel_code == 3'b010, "R4 explicit", 48'(rel_code), 48'd2);
        // R5: same value, different encoding
        cmp_case(mkw(0, 0, 0, 39'o10), mkw(0, 0, 1, 39'o1), 3'd5, "R5");
        check(rel_code == 3'b001, "R5 equal encodings", 48'(rel_code), 48'd1);
        cmp_case(mkw(0, 0, 2, 39'o1), mkw(0, 0, 0, 39'o7777), 3'd4, "R5");
        cmp_case(mkw(0, 0, 0, 39'o4000000000000), mkw(0, 0, 0, 39'o3777777777777), 3'd1, "R5");
        // R6: both negative
        cmp_case(mkw(0, 1, 2, 39'o5), mkw(0, 1, 2, 39'o3), 3'd4, "R6");
        check(rel_code == 3'b010, "R6 explicit", 48'(rel_code), 48'd2);
        // R9: flag bit ignored
        cmp_case(mkw(1, 0, 1, 39'o6), mkw(0, 0, 1, 39'o6), 3'd5, "R9");
        check(rel_code == 3'b001, "R9 flag", 48'(rel_code), 48'd1);
        cmp_case(mkw(0, 0, 1, 39'o6), mkw(1, 0, 1, 39'o5), 3'd1, "R9");

        // R7: every select over less, equal, greater
        for (int sel = 0; sel < 8; sel++) begin
            cmp_case(mkw(0, 0, 0, 39'o3), mkw(0, 0, 0, 39'o5), 3'(sel), "R7");
            cmp_case(mkw(0, 0, 0, 39'o5), mkw(0, 0, 0, 39'o5), 3'(sel), "R7");
            cmp_case(mkw(0, 0, 0, 39'o7), mkw(0, 0, 0, 39'o5), 3'(sel), "R7");
        end

        // R8 and R5: deepest normalization, latency bound, pulse, busy release
        run_op(mkw(0, 0, 4, 39'o1), mkw(0, 0, 3, 39'o1), 3'd1, lat);
        check(lat <= 16, "R8 latency", 48'(lat), 48'd16);
        check(rel_code == 3'b100, "R5 deep shift", 48'(rel_code), 48'd4);
        @(negedge clk);
        check(done == 1'b0, "R8 done pulse", 48'(done), 48'd0);
        check(busy == 1'b0, "R8 busy release", 48'(busy), 48'd0);

        // R8: start while busy ignored
        @(negedge clk);
        second_word = mkw(0, 0, 0, 39'o1); top_word = mkw(0, 0, 0, 39'o2);
        pred_sel = 3'd4; start = 1'b1;
        @(negedge clk);
        check(busy == 1'b1, "R8 busy", 48'(busy), 48'd1);
        second_word = mkw(0, 0, 0, 39'o7); top_word = mkw(0, 0, 0, 39'o2); pred_sel = 3'd1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 40) begin @(negedge clk); lat++; end
        check(rel_code == 3'b010, "R8 ignore code", 48'(rel_code), 48'd2);
        check(pred_word == 48'd1, "R8 ignore sel", pred_word, 48'd1);

        // Random mix, R1 and R5 primarily
        for (int i = 0; i < 200; i++) begin
            int kind = int'($urandom % 4);
            int e1 = int'($urandom % 7) - 3;
            int p  = int'($urandom % 12);
            logic [38:0] m1 = 39'($urandom % 7 + 1) << (3 * p);
            logic [38:0] m2 = 39'({$urandom, $urandom});
            bit n1 = $urandom % 2;
            if (kind == 0) begin
                s = mkw($urandom % 2, n1, e1 - 1, m1 << 3);
                t = mkw($urandom % 2, n1, e1, m1);
            end else if (kind == 1) begin
                s = mkw(0, n1, e1, m1);
                t = mkw(0, n1, int'($urandom % 7) - 3, m2 >> (3 * ($urandom % 13)));
            end else if (kind == 2) begin
                s = mkw(0, n1, e1, m2);
                t = mkw(0, !n1, int'($urandom % 7) - 3, m1);
            end else begin
                s = mkw(0, n1, e1, ($urandom % 2) ? 39'd0 : m1);
                t = mkw(0, $urandom % 2, 2, ($urandom % 2) ? 39'd0 : m2);
            end
            if ($urandom % 2) cmp_case(s, t, 3'($urandom % 8), "R1");
            else              cmp_case(t, s, 3'($urandom % 8), "R5");
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule